// File: doc/BRIEF.md
# Glitch-Free Machine-Cycle Clock Mode Controller

This block decides how many reference-clock ticks make up one machine cycle. It emits a single-cycle strobe that the rest of the chip uses as its machine-cycle enable. The reference clock runs at four times the crystal rate. The block holds three values: a two-bit rate code, a multiplier-enable bit and a double/quadruple rate select. Software updates them through a small write port, one register per address.

The controller screens every write and only accepts safe mode changes. Every move of the rate code must go through the divide-by-4 code. Engaging the frequency multiplier needs an ordered arm sequence, and the sequence ends with a simulated warm-up of the multiplier. Writes that break these rules are dropped without any notice. An accepted rate code does not change the strobe spacing at once. It takes effect when the machine cycle in progress ends, so no machine cycle is ever cut short or stretched.

Top module: `mcyc_clock_governor`

## Requirements
- R1: After reset the rate code is 2'b10 (divide-by-4), the multiplier enable, the rate select and the ready flag are all 0, and strobes come every 16 reference clocks.
- R2: The strobe is high for exactly one reference clock. Its spacing depends on the mode: code 2'b10 gives 16 clocks, code 2'b11 (power saving) gives 4096, code 2'b00 with rate select 0 gives 8, and code 2'b00 with rate select 1 gives 4.
- R3: A write of the reserved code 2'b01 to the rate-code register (address 0, data bits [1:0]) is dropped.
- R4: The rate code may move to 2'b11 only from 2'b10. A write of 2'b11 while the code is 2'b00 is dropped, and so is a write of 2'b00 while the code is 2'b11.
- R5: A write of 2'b00 is taken only when all of these hold: the code is 2'b10, the multiplier enable is set, the ready flag is 1, and the arm steps happened in this order: enable cleared (address 1, data bit 0 = 0), then rate select written (address 2, data bit 0), then enable set (address 1, data bit 0 = 1). Once the write is taken, the step tracker starts over, so a later re-entry needs the full sequence again.
- R6: If the steps come out of order, the 2'b00 write is dropped. Examples are writing the rate select before clearing the enable, or setting the enable without writing the rate select in between.
- R7: Other writes between the arm steps do not break the sequence. This covers rate-code writes, dropped writes and writes to the unused address 3.
- R8: A 2'b00 write is dropped while the regeneration-hold input is high. The armed sequence is kept, so a later 2'b00 write can still be taken.
- R9: The ready flag rises exactly WARM_OSC*4 reference clocks after the multiplier enable becomes set.
- R10: A write that clears the multiplier enable drops the ready flag in the same clock edge and restarts the warm-up count from zero. The ready flag is never high while the enable is clear.
- R11: A rate-select write is ignored while the multiplier enable is set.
- R12: When a new rate code is taken, the machine cycle in progress finishes at the old spacing, and the following one uses the new spacing.
- R13: From code 2'b00, a write of 2'b10 is taken at once, with no other steps needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the crystal rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 2 | 0 rate code, 1 multiplier enable, 2 rate select, 3 unused |
| wr_data_i | input | 2 | Write data (bits [1:0] for the code, bit 0 for the others) |
| regen_hold_i | input | 1 | External hold; blocks multiplier entry while high |
| div_code_o | output | 2 | Current rate code |
| rate_sel_o | output | 1 | Current rate select (0 double, 1 quadruple) |
| men_o | output | 1 | Current multiplier enable |
| ready_o | output | 1 | Multiplier warm-up complete |
| mc_stb_o | output | 1 | Machine-cycle strobe, one clock wide |

## Verification
The following are checked on every cycle by the bound checker:
- the reserved code never appears;
- every code change touches divide-by-4;
- multiplier entry only follows a cycle with ready and enable set and the hold low;
- ready never stands without the enable;
- the strobe is never two cycles wide;
- the rate select stays frozen while the enable is held.

Only the bench's scenarios can show the rest: the exact strobe spacing in each mode, the exact warm-up length, the order-sensitive arm sequence with interleaved and misordered writes, and the fact that a mode change waits for the end of the current machine cycle.

// File: rtl/clkgov_pkg.sv
package clkgov_pkg;

    typedef enum logic [1:0] {
        CODE_MULT = 2'b00,
        CODE_RSVD = 2'b01,
        CODE_DIV4 = 2'b10,
        CODE_PMM  = 2'b11
    } div_code_e;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_CLEARED = 2'd1,
        SEQ_RATE    = 2'd2,
        SEQ_ARMED   = 2'd3
    } arm_seq_e;

    localparam logic [1:0] ADDR_CODE = 2'd0;
    localparam logic [1:0] ADDR_MEN  = 2'd1;
    localparam logic [1:0] ADDR_RATE = 2'd2;

endpackage

// File: rtl/clkgov_mode_guard.sv
module clkgov_mode_guard
    import clkgov_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [1:0] wr_data_i,
    input  logic       regen_hold_i,
    input  logic       ready_i,
    output div_code_e  code_o,
    output logic       men_o,
    output logic       rate_o,
    output logic       arm_clr_o
);

    typedef struct packed {
        div_code_e code;
        logic      men;
        logic      rate;
        arm_seq_e  seq;
    } guard_t;

    guard_t st_d, st_q;
    logic   entry_ok;

    assign entry_ok = (st_q.code == CODE_DIV4) && !regen_hold_i && st_q.men
                      && ready_i && (st_q.seq == SEQ_ARMED);

    always_comb begin
        st_d      = st_q;
        arm_clr_o = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CODE: begin
                    case (wr_data_i)
                        2'b10: st_d.code = CODE_DIV4;
                        2'b11: if (st_q.code != CODE_MULT) st_d.code = CODE_PMM;
                        2'b00: if (st_q.code != CODE_MULT && entry_ok) begin
                            st_d.code = CODE_MULT;
                            st_d.seq  = SEQ_IDLE;
                        end
                        default: ;
                    endcase
                end
                ADDR_MEN: begin
                    if (!wr_data_i[0]) begin
                        st_d.men  = 1'b0;
                        st_d.seq  = SEQ_CLEARED;
                        arm_clr_o = 1'b1;
                    end else if (!st_q.men) begin
                        st_d.men = 1'b1;
                        st_d.seq = (st_q.seq == SEQ_RATE) ? SEQ_ARMED : SEQ_IDLE;
                    end
                end
                ADDR_RATE: begin
                    if (!st_q.men) begin
                        st_d.rate = wr_data_i[0];
                        if (st_q.seq == SEQ_CLEARED || st_q.seq == SEQ_RATE)
                            st_d.seq = SEQ_RATE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= CODE_DIV4;
            st_q.men  <= 1'b0;
            st_q.rate <= 1'b0;
            st_q.seq  <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign men_o  = st_q.men;
    assign rate_o = st_q.rate;

endmodule

// File: rtl/clkgov_warmup.sv
module clkgov_warmup #(
    parameter int LIMIT = 262144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic men_i,
    input  logic arm_clr_i,
    output logic ready_o
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } warm_t;

    warm_t wm_d, wm_q;

    always_comb begin
        wm_d = wm_q;
        if (arm_clr_i) begin
            wm_d.cnt   = '0;
            wm_d.ready = 1'b0;
        end else if (men_i && !wm_q.ready) begin
            if (wm_q.cnt == CW'(LIMIT - 1))
                wm_d.ready = 1'b1;
            else
                wm_d.cnt = wm_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q.cnt   <= '0;
            wm_q.ready <= 1'b0;
        end else begin
            wm_q <= wm_d;
        end
    end

    assign ready_o = wm_q.ready;

endmodule

// File: rtl/clkgov_strobe.sv
module clkgov_strobe
    import clkgov_pkg::*;
#(
    parameter int P_DIV4 = 16,
    parameter int P_PMM  = 4096,
    parameter int P_2X   = 8,
    parameter int P_4X   = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  div_code_e code_i,
    input  logic      rate_i,
    output logic      stb_o
);

    localparam int PW = $clog2(P_PMM);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } stb_t;

    stb_t sb_d, sb_q;
    logic [PW-1:0] reload;

    always_comb begin
        case (code_i)
            CODE_MULT: reload = rate_i ? PW'(P_4X - 1) : PW'(P_2X - 1);
            CODE_PMM:  reload = PW'(P_PMM - 1);
            default:   reload = PW'(P_DIV4 - 1);
        endcase
    end

    always_comb begin
        sb_d = sb_q;
        if (sb_q.cnt == '0)
            sb_d.cnt = reload;
        else
            sb_d.cnt = sb_q.cnt - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q.cnt <= '0;
        else        sb_q     <= sb_d;
    end

    assign stb_o = (sb_q.cnt == '0);

endmodule

// File: rtl/mcyc_clock_governor.sv
module mcyc_clock_governor
    import clkgov_pkg::*;
#(
    parameter int REF_PER_OSC = 4,
    parameter int DIV4_OSC    = 4,
    parameter int PMM_OSC     = 1024,
    parameter int WARM_OSC    = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [1:0] wr_data_i,
    input  logic       regen_hold_i,
    output logic [1:0] div_code_o,
    output logic       rate_sel_o,
    output logic       men_o,
    output logic       ready_o,
    output logic       mc_stb_o
);

    localparam int P_DIV4 = DIV4_OSC * REF_PER_OSC;
    localparam int P_PMM  = PMM_OSC * REF_PER_OSC;
    localparam int P_2X   = 2 * REF_PER_OSC;
    localparam int P_4X   = REF_PER_OSC;
    localparam int WLIM   = WARM_OSC * REF_PER_OSC;

    div_code_e code;
    logic      men, rate, ready, arm_clr;

    clkgov_mode_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .regen_hold_i (regen_hold_i),
        .ready_i      (ready),
        .code_o       (code),
        .men_o        (men),
        .rate_o       (rate),
        .arm_clr_o    (arm_clr)
    );

    clkgov_warmup #(.LIMIT(WLIM)) u_warm (
        .clk       (clk),
        .rst_n     (rst_n),
        .men_i     (men),
        .arm_clr_i (arm_clr),
        .ready_o   (ready)
    );

    clkgov_strobe #(
        .P_DIV4 (P_DIV4),
        .P_PMM  (P_PMM),
        .P_2X   (P_2X),
        .P_4X   (P_4X)
    ) u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code),
        .rate_i (rate),
        .stb_o  (mc_stb_o)
    );

    assign div_code_o = code;
    assign rate_sel_o = rate;
    assign men_o      = men;
    assign ready_o    = ready;

endmodule

// File: rtl/mcyc_clock_governor_chk.sv
module mcyc_clock_governor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       regen_hold_i,
    input logic [1:0] div_code_o,
    input logic       rate_sel_o,
    input logic       men_o,
    input logic       ready_o,
    input logic       mc_stb_o
);

    p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_code_o != 2'b01);

    p_via_div4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code_o != $past(div_code_o)) |-> (div_code_o == 2'b10 || $past(div_code_o) == 2'b10));

    p_mult_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code_o == 2'b00 && $past(div_code_o) != 2'b00)
        |-> ($past(ready_o) && $past(men_o) && !$past(regen_hold_i) && $past(div_code_o) == 2'b10));

    p_ready_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> men_o);

    p_single_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb_o |=> !mc_stb_o);

    p_rate_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(men_o) && men_o) |-> $stable(rate_sel_o));

    p_ready_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(men_o));

endmodule

bind mcyc_clock_governor mcyc_clock_governor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .regen_hold_i (regen_hold_i),
    .div_code_o   (div_code_o),
    .rate_sel_o   (rate_sel_o),
    .men_o        (men_o),
    .ready_o      (ready_o),
    .mc_stb_o     (mc_stb_o)
);

// File: tb/mcyc_clock_governor_test.sv
module mcyc_clock_governor_test;

    localparam int WARM = 16;
    localparam int WLIM = WARM * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic       regen_hold = 1'b0;
    logic [1:0] div_code;
    logic       rate_sel, men, ready, mc_stb;

    int n_total = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    mcyc_clock_governor #(.WARM_OSC(WARM)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .regen_hold_i (regen_hold),
        .div_code_o   (div_code),
        .rate_sel_o   (rate_sel),
        .men_o        (men),
        .ready_o      (ready),
        .mc_stb_o     (mc_stb)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // monitor: measure strobe spacing and compare with queued expectations
    initial begin
        int cyc = 0;
        int last = 0;
        bit have_last = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n && mc_stb) begin
                if (have_last && exp_q.size() != 0)
                    check(tag_q.pop_front(), cyc - last, exp_q.pop_front());
                last = cyc;
                have_last = 1'b1;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_stb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!mc_stb) @(negedge clk);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic expect_steady(input int p, input int n, input string tag);
        wait_stb(2);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(p);
            tag_q.push_back(tag);
        end
        drain();
    endtask

    task automatic ready_delay(output int n);
        n = 0;
        while (!ready && n < 4 * WLIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 code", div_code, 2);
        check("R1 men", men, 0);
        check("R1 rate", rate_sel, 0);
        check("R1 ready", ready, 0);
        expect_steady(16, 2, "R1 div4 spacing");

        // R3 reserved code
        wr(2'd0, 2'b01);
        check("R3 reserved dropped", div_code, 2);

        // R4 power saving only via divide-by-4
        wr(2'd0, 2'b11);
        check("R4 enter pmm", div_code, 3);
        expect_steady(4096, 2, "R2 pmm spacing");
        wr(2'd0, 2'b00);
        check("R4 pmm to mult dropped", div_code, 3);

        // R12 change applies at next boundary
        repeat (100) @(negedge clk);
        wr(2'd0, 2'b10);
        check("R12 code written", div_code, 2);
        exp_q.push_back(4096); tag_q.push_back("R12 old spacing kept");
        exp_q.push_back(16);   tag_q.push_back("R12 new spacing");
        drain();

        // R6 out of order: rate written before clear, enable set without sequence
        wr(2'd2, 2'b01);
        check("R6 rate while disabled", rate_sel, 1);
        wr(2'd1, 2'b01);
        ready_delay(n);
        check("R9 warm-up length first", n, WLIM);
        wr(2'd0, 2'b00);
        check("R6 misordered entry dropped", div_code, 2);

        // R11 rate locked while enabled
        wr(2'd2, 2'b00);
        check("R11 rate unchanged", rate_sel, 1);

        // R10 clear drops ready immediately
        wr(2'd1, 2'b00);
        check("R10 men cleared", men, 0);
        check("R10 ready cleared", ready, 0);

        // R7 interleaved writes during proper sequence
        wr(2'd0, 2'b10);
        wr(2'd2, 2'b01);
        wr(2'd3, 2'b11);
        wr(2'd0, 2'b01);
        wr(2'd1, 2'b01);
        ready_delay(n);
        check("R9 warm-up length", n, WLIM);
        regen_hold = 1'b1;
        wr(2'd0, 2'b00);
        check("R8 hold blocks entry", div_code, 2);
        regen_hold = 1'b0;
        wr(2'd0, 2'b00);
        check("R7 R5 entry accepted", div_code, 0);
        expect_steady(4, 3, "R2 quad spacing");

        // R4 / R13 leaving the multiplier
        wr(2'd0, 2'b11);
        check("R4 mult to pmm dropped", div_code, 0);
        wr(2'd0, 2'b10);
        check("R13 leave mult", div_code, 2);
        wr(2'd0, 2'b00);
        check("R5 tracker restarted", div_code, 2);

        // R10 counter restart mid warm-up, then double rate entry
        wr(2'd1, 2'b00);
        wr(2'd2, 2'b00);
        wr(2'd1, 2'b01);
        repeat (20) @(negedge clk);
        wr(2'd1, 2'b00);
        check("R10 ready low after restart", ready, 0);
        wr(2'd2, 2'b00);
        wr(2'd1, 2'b01);
        ready_delay(n);
        check("R10 warm-up restarted from zero", n, WLIM);
        wr(2'd0, 2'b00);
        check("R5 double entry", div_code, 0);
        check("R5 rate double", rate_sel, 0);
        expect_steady(8, 3, "R2 double spacing");

        finish_run();
    end

endmodule